// File: doc/BRIEF.md
# Stereo DC Offset Trim Stage

This block sits after the decimation filter of a two-channel audio converter path. It removes any constant bias from the sample streams. Each channel keeps a running estimate of its DC level in a first-order leaky integrator. The integrator holds fractional bits below the sample LSB. The integer part of the estimate is subtracted from every incoming sample, and the difference is clamped to the signed sample range.

Each channel has two controls.
- **Enable.** While enable is low, the channel's samples pass through untouched so that true DC levels can be measured.
- **Freeze.** While freeze is high, the estimate stops tracking but is still subtracted.

A system offset calibration uses these controls in a fixed order. First run with the channel enabled and unfrozen until the estimate settles. Then raise freeze to lock the learned offset.

Top module: `dc_trim_stereo`

## Requirements
- R1: A synchronous reset (`rst` high) clears `out_valid` to 0 and both offset estimates to zero. The first enabled sample after reset therefore leaves the block unchanged.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock. Output data is registered in the same cycle.
- R3: For an enabled channel, each output equals the input minus floor(E / 2^FRAC), where E is the estimate before the update. If enabled and not frozen, E then becomes E + floor((x·2^FRAC − E) / 2^SHIFT).
- R4: The estimates change only on clock cycles where `in_valid` is high.
- R5: While a channel's freeze input is high, its estimate is held. Every sample on that channel still has the held value subtracted from it.
- R6: When freeze is released, the estimate resumes updating from its held value on the next valid sample, with no jump.
- R7: While a channel's enable input is low, its output equals its input exactly and its estimate is unchanged. Re-enabling resumes from the held estimate.
- R8: The subtraction saturates to the range −8388608 to +8388607 (with the default 24-bit width) instead of wrapping.
- R9: The two channels operate independently. One channel's controls and data never affect the other channel's output.
- R10: With a constant input on an enabled, unfrozen channel, the output settles to within ±2 LSB of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe shared by both channels |
| in_a | input | 24 | Channel A sample, signed two's complement |
| in_b | input | 24 | Channel B sample, signed two's complement |
| en_a | input | 1 | Channel A filter enable (0 = bypass) |
| frz_a | input | 1 | Channel A estimate freeze |
| en_b | input | 1 | Channel B filter enable (0 = bypass) |
| frz_b | input | 1 | Channel B estimate freeze |
| out_valid | output | 1 | Output strobe, one cycle after `in_valid` |
| out_a | output | 24 | Channel A result, signed |
| out_b | output | 24 | Channel B result, signed |

## Verification
The assertions assume that enable, freeze and the data inputs are stable across each clock edge. They also assume these inputs are meaningful even in cycles without a valid strobe, because the hold properties look at the estimate in every cycle, not only on strobes. The stimulus drives every input on the falling edge, one value per cycle. It spreads valid gaps, freeze toggles and enable toggles over independent random streams, so each hold condition occurs both with and without a strobe. The saturation property assumes the estimate never leaves the sample range. The stimulus tests this at its limit: it drives both channels to opposite full-scale DC levels, freezes them, and then applies the opposite extreme.

// File: rtl/dctrim_pkg.sv
package dctrim_pkg;

   localparam int DEF_SAMPLE_W = 24;
   localparam int DEF_FRAC_W   = 12;
   localparam int DEF_SHIFT    = 10;

   typedef struct packed {
      logic en;
      logic frz;
   } lane_ctl_t;

endpackage

// File: rtl/dctrim_est.sv
module dctrim_est #(
   parameter int W = 24,
   parameter int F = 12,
   parameter int K = 10
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                upd,
   input  logic signed [W-1:0] x,
   output logic signed [W-1:0] est_int
);

   localparam int EW = W + F;

   logic signed [EW-1:0] acc;
   logic signed [EW-1:0] x_ext;
   logic signed [EW:0]   diff;
   logic signed [EW:0]   diff_sh;
   logic signed [EW-1:0] step;

   always_comb begin
      x_ext   = $signed({x, {F{1'b0}}});
      diff    = $signed({x_ext[EW-1], x_ext}) - $signed({acc[EW-1], acc});
      diff_sh = diff >>> K;
      step    = diff_sh[EW-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc <= '0;
      end else if (upd) begin
         acc <= acc + step;
      end
   end

   assign est_int = acc[EW-1:F];

endmodule

// File: rtl/dctrim_clip.sv
module dctrim_clip #(
   parameter int W   = 24,
   parameter bit SAT = 1'b1
) (
   input  logic signed [W-1:0] x,
   input  logic signed [W-1:0] e,
   output logic signed [W-1:0] y
);

   logic signed [W:0] d;

   assign d = $signed({x[W-1], x}) - $signed({e[W-1], e});

   generate
      if (SAT) begin : g_clamp
         always_comb begin
            if (d[W] != d[W-1]) begin
               y = d[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
            end else begin
               y = d[W-1:0];
            end
         end
      end else begin : g_wrap
         logic unused_top;
         assign unused_top = d[W];
         assign y = d[W-1:0];
      end
   endgenerate

endmodule

// File: rtl/dctrim_lane.sv
module dctrim_lane
   import dctrim_pkg::*;
#(
   parameter int W   = 24,
   parameter int F   = 12,
   parameter int K   = 10,
   parameter bit SAT = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                vld,
   input  logic signed [W-1:0] x,
   input  lane_ctl_t           ctl,
   output logic signed [W-1:0] y
);

   logic                upd;
   logic signed [W-1:0] est_int;
   logic signed [W-1:0] trimmed;

   assign upd = vld & ctl.en & ~ctl.frz;

   dctrim_est #(.W(W), .F(F), .K(K)) i_est (
      .clk     (clk),
      .rst     (rst),
      .upd     (upd),
      .x       (x),
      .est_int (est_int)
   );

   dctrim_clip #(.W(W), .SAT(SAT)) i_clip (
      .x (x),
      .e (est_int),
      .y (trimmed)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         y <= '0;
      end else if (vld) begin
         y <= ctl.en ? trimmed : x;
      end
   end

   // R4
   est_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !vld |=> $stable(est_int));

   // R5
   frz_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ctl.frz |=> $stable(est_int));

   // R7
   dis_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !ctl.en |=> $stable(est_int));

   // R7
   bypass_chk: assert property (@(posedge clk) disable iff (rst)
      (vld && !ctl.en) |=> (y == $past(x)));

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      (vld && ctl.en && !x[W-1] && est_int[W-1]) |=> !y[W-1]);

endmodule

// File: rtl/dc_trim_stereo.sv
module dc_trim_stereo
   import dctrim_pkg::*;
#(
   parameter int SAMPLE_W = DEF_SAMPLE_W,
   parameter int FRAC_W   = DEF_FRAC_W,
   parameter int SHIFT    = DEF_SHIFT,
   parameter bit SATURATE = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       in_valid,
   input  logic signed [SAMPLE_W-1:0] in_a,
   input  logic signed [SAMPLE_W-1:0] in_b,
   input  logic                       en_a,
   input  logic                       frz_a,
   input  logic                       en_b,
   input  logic                       frz_b,
   output logic                       out_valid,
   output logic signed [SAMPLE_W-1:0] out_a,
   output logic signed [SAMPLE_W-1:0] out_b
);

   localparam int NCH = 2;

   generate
      if (SAMPLE_W < 2) begin : g_bad_w
         $error("SAMPLE_W must be at least 2");
      end
      if (SHIFT < 1 || SHIFT >= SAMPLE_W + FRAC_W) begin : g_bad_k
         $error("SHIFT out of range for accumulator width");
      end
      if (FRAC_W < 0) begin : g_bad_f
         $error("FRAC_W must be non-negative");
      end
   endgenerate

   logic signed [SAMPLE_W-1:0] lane_in  [NCH];
   logic signed [SAMPLE_W-1:0] lane_out [NCH];
   lane_ctl_t                  lane_ctl [NCH];

   assign lane_in[0]  = in_a;
   assign lane_in[1]  = in_b;
   assign lane_ctl[0] = '{en: en_a, frz: frz_a};
   assign lane_ctl[1] = '{en: en_b, frz: frz_b};

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_lane
         dctrim_lane #(
            .W   (SAMPLE_W),
            .F   (FRAC_W),
            .K   (SHIFT),
            .SAT (SATURATE)
         ) i_lane (
            .clk (clk),
            .rst (rst),
            .vld (in_valid),
            .x   (lane_in[c]),
            .ctl (lane_ctl[c]),
            .y   (lane_out[c])
         );
      end
   endgenerate

   assign out_a = lane_out[0];
   assign out_b = lane_out[1];

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
      end
   end

   // R2
   vld_lat_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R2
   vld_drop_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

endmodule

// File: tb/test_dc_trim_stereo.sv
module test_dc_trim_stereo;

   localparam int  W    = 24;
   localparam int  F    = 12;
   localparam int  K    = 10;
   localparam longint MAXV = 8388607;
   localparam longint MINV = -8388608;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic signed [W-1:0] in_a = '0;
   logic signed [W-1:0] in_b = '0;
   logic en_a = 1'b0, frz_a = 1'b0, en_b = 1'b0, frz_b = 1'b0;
   logic out_valid;
   logic signed [W-1:0] out_a, out_b;

   always #5 clk = ~clk;

   dc_trim_stereo #(.SAMPLE_W(W), .FRAC_W(F), .SHIFT(K), .SATURATE(1'b1)) i_dc_trim_stereo (
      .clk (clk), .rst (rst), .in_valid (in_valid),
      .in_a (in_a), .in_b (in_b),
      .en_a (en_a), .frz_a (frz_a), .en_b (en_b), .frz_b (frz_b),
      .out_valid (out_valid), .out_a (out_a), .out_b (out_b)
   );

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   longint est_m [2];
   bit     exp_v = 1'b0;
   longint exp_y [2];
   string  exp_tag = "R1";

   task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   endtask

   function automatic longint model_ch(input int c, input longint x, input bit v,
                                       input bit en, input bit fz);
      longint ei, d, r;
      ei = est_m[c] >>> F;
      d  = x - ei;
      if (d > MAXV) d = MAXV;
      if (d < MINV) d = MINV;
      r = en ? d : x;
      if (v && en && !fz) est_m[c] = est_m[c] + (((x <<< F) - est_m[c]) >>> K);
      return r;
   endfunction

   task automatic compare_prev();
      chk(out_valid == exp_v, {exp_tag, " R2 out_valid"}, longint'(out_valid), longint'(exp_v));
      if (exp_v) begin
         chk(longint'(out_a) == exp_y[0], {exp_tag, " ch A"}, longint'(out_a), exp_y[0]);
         chk(longint'(out_b) == exp_y[1], {exp_tag, " ch B"}, longint'(out_b), exp_y[1]);
      end
   endtask

   task automatic drive(input bit v, input longint xa, input longint xb,
                        input bit ea, input bit fa, input bit eb, input bit fb,
                        input string tag);
      longint ya, yb;
      @(negedge clk);
      compare_prev();
      in_valid = v; in_a = W'(xa); in_b = W'(xb);
      en_a = ea; frz_a = fa; en_b = eb; frz_b = fb;
      ya = model_ch(0, xa, v, ea, fa);
      yb = model_ch(1, xb, v, eb, fb);
      exp_v = v;
      if (v) begin
         exp_y[0] = ya;
         exp_y[1] = yb;
      end
      exp_tag = tag;
   endtask

   function automatic longint rnd24();
      logic signed [W-1:0] r;
      r = W'($urandom);
      return longint'(r);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      report();
   end

   initial begin
      est_m[0] = 0; est_m[1] = 0;
      exp_y[0] = 0; exp_y[1] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1: reset state of the output strobe
      chk(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
      // R1: first enabled sample sees a zero estimate
      drive(1, 1234, -777, 1, 0, 1, 0, "R1");
      // R2 R3 R4 R9: A filtered, B bypassed (R7), gaps in valid
      for (int i = 0; i < 400; i++)
         drive(($urandom % 3) != 0, rnd24(), rnd24(), 1, 0, 0, 0, "R3 R4 R9 R7");
      // R3 R10: settle to opposite full-scale DC levels
      for (int i = 0; i < 20000; i++)
         drive(1, MINV, MAXV, 1, 0, 1, 0, "R3");
      drive(0, 0, 0, 1, 0, 1, 0, "R3");
      @(negedge clk);
      compare_prev();
      chk(out_a >= -2 && out_a <= 2, "R10 settled A", longint'(out_a), 0);
      chk(out_b >= -2 && out_b <= 2, "R10 settled B", longint'(out_b), 0);
      // R5 R8: freeze, then apply the opposite extreme
      for (int i = 0; i < 8; i++)
         drive(1, MAXV, MINV, 1, 1, 1, 1, "R5 R8");
      drive(0, 0, 0, 1, 1, 1, 1, "R5 R8");
      @(negedge clk);
      compare_prev();
      chk(longint'(out_a) == MAXV, "R8 clamp high", longint'(out_a), MAXV);
      chk(longint'(out_b) == MINV, "R8 clamp low", longint'(out_b), MINV);
      // R6: release A, B stays frozen (R9)
      for (int i = 0; i < 300; i++)
         drive(1, 5000 + (rnd24() >>> 12), rnd24(), 1, 0, 1, 1, "R6 R9");
      // R7: disable B, then re-enable
      for (int i = 0; i < 300; i++)
         drive(($urandom % 4) != 0, rnd24(), rnd24(), 1, 0, 0, 0, "R7");
      for (int i = 0; i < 300; i++)
         drive(1, rnd24(), rnd24() >>> 4, 1, 0, 1, 0, "R7");
      // R3 R5 R6 R7 R9: all controls random
      for (int i = 0; i < 3000; i++)
         drive(($urandom % 3) != 0, rnd24(), rnd24(),
               ($urandom % 5) != 0, ($urandom % 3) == 0,
               ($urandom % 5) != 0, ($urandom % 3) == 0, "R3 R5 R6 R7 R9");
      drive(0, 0, 0, 1, 0, 1, 0, "R2");
      @(negedge clk);
      compare_prev();
      report();
   end

endmodule